// File: doc/BRIEF.md
# Programmable Decoder Target Lookup

This block keeps a small bank of programmable address decoders and answers, for a host physical address, which 8-bit downstream port number serves it. Each decoder holds a 256 MiB-aligned base and size, a control word (interleave granularity, interleave ways and a committed flag) and a two-word list of eight one-byte port numbers. A capability word sets how many decoders take part in the search.

Software programs the bank through a plain register port: one write strobe, a word address, write data and a combinational read-back. A lookup is a single-cycle request strobe with an address. The result (a valid strobe, a found flag and the port number) appears exactly two clock edges later. Requests may be issued back to back, one per cycle.

Decoders are examined from index 0 upward. The first decoder whose window holds the address decides the outcome, even when that decoder is not committed. In that case the lookup misses and no later decoder is consulted.

Top module: `addr_route_lookup`

Register map (word addresses): word 0 is the capability word. Decoder k occupies words 8*(k+1) to 8*(k+1)+6, at these offsets:

| Offset | Contents |
|---|---|
| 0 | base low (only bits 31:28 stored) |
| 1 | base high |
| 2 | size low (only bits 31:28 stored) |
| 3 | size high |
| 4 | control |
| 5 | target list low |
| 6 | target list high |

Unmapped words read as zero.

## Requirements
- R1: Capability word 0, bits 3:0, hold a count code C. The active decoder count is 1 when C=0 and 2*C otherwise, capped at NUM_DEC. Decoders at or above the active count never match.
- R2: Base and size are 64-bit values built from the high word (bits 63:32) and bits 31:28 of the low word, with bits 27:0 always zero. Reading a low word returns its bits 31:28 and zeros below.
- R3: A decoder matches an address A when base <= A < base + size. The lower bound is inclusive and the upper bound is exclusive.
- R4: When several decoders match, the lowest-index one decides the result.
- R5: If the lowest-index matching decoder has its committed bit (control bit 8) clear, the result is not found, even if a later decoder matches and is committed.
- R6: If no active decoder matches, the result is not found.
- R7: The target index is (A >> (8 + G)) mod 2^W. G is control bits 3:0, so the granularity is 256 bytes shifted left by G. W is control bits 5:4, giving 1, 2, 4 or 8 ways.
- R8: Indices 0 to 3 select byte (index) of the target list low word, at bits index*8+7 down to index*8. Indices 4 to 7 select byte (index-4) of the target list high word. The selected byte is the reported port.
- R9: For a request presented in one cycle, rs_valid is high exactly two rising edges later, for one cycle. When rs_valid or rs_found is low, rs_port is zero.
- R10: While a decoder's committed bit is set, writes to its base, size and target-list words are ignored. Its control word stays writable, and once the committed bit is cleared those writes take effect again.
- R11: Reset clears every register, so all reads return zero and rs_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 64 | Host physical address to look up |
| rs_valid | output | 1 | Lookup result strobe, two cycles after the request |
| rs_found | output | 1 | A committed decoder served the address |
| rs_port | output | 8 | Selected port number (zero when not found) |

## Verification
Lookups are tried with addresses that:
- sweep every interleave slot of a 4-way and an 8-way decoder, which separates an index taken from the wrong address bits, or a byte taken from the wrong target word;
- sit exactly on each lower bound and on the last byte below each upper bound, and one byte past it, which separates inclusive from exclusive compares;
- fall in two overlapping windows, first with the lower one uncommitted and then committed, which separates stop-on-first-match from continuing the search.

Changing the count code between 0, 1, 2 and an over-range value shows which decoders take part in the search. Writes made while a decoder is committed, and again after its commit is cleared, show the write lock through read-back and through later lookups.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

   localparam int DW        = 32;
   localparam int HPA_W     = 64;
   localparam int PORT_W    = 8;
   localparam int WORDS_PER = 8;

   // word offsets inside one decoder block
   localparam logic [2:0] OFS_BASE_LO = 3'd0;
   localparam logic [2:0] OFS_BASE_HI = 3'd1;
   localparam logic [2:0] OFS_SIZE_LO = 3'd2;
   localparam logic [2:0] OFS_SIZE_HI = 3'd3;
   localparam logic [2:0] OFS_CTRL    = 3'd4;
   localparam logic [2:0] OFS_TGT_LO  = 3'd5;
   localparam logic [2:0] OFS_TGT_HI  = 3'd6;

   // control word bit positions
   localparam int CTRL_COMMIT = 8;

   typedef struct packed {
      logic [31:0] base_hi;
      logic [3:0]  base_top;
      logic [31:0] size_hi;
      logic [3:0]  size_top;
      logic [3:0]  gran;
      logic [1:0]  ways;
      logic        commit;
      logic [31:0] tgt_lo;
      logic [31:0] tgt_hi;
   } dec_cfg_t;

endpackage

// File: rtl/route_cfg_bank.sv
module route_cfg_bank
   import addr_route_pkg::*;
#(
   parameter int NUM_DEC = 4,
   parameter int CFG_AW  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_AW-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   output logic [3:0]        cnt_code,
   output dec_cfg_t          cfg [NUM_DEC]
);

   localparam int BLK_W = CFG_AW - 3;

   logic [BLK_W-1:0] blk;
   logic [2:0]       ofs;

   assign blk = addr[CFG_AW-1:3];
   assign ofs = addr[2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_code <= '0;
      else if (we && addr == '0)
         cnt_code <= wdata[3:0];
   end

   for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
      logic sel;
      logic locked;

      assign sel    = we && (blk == BLK_W'(i + 1));
      assign locked = cfg[i].commit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg[i] <= '0;
         end else if (sel) begin
            case (ofs)
               OFS_CTRL: begin
                  cfg[i].gran   <= wdata[3:0];
                  cfg[i].ways   <= wdata[5:4];
                  cfg[i].commit <= wdata[CTRL_COMMIT];
               end
               OFS_BASE_LO: if (!locked) cfg[i].base_top <= wdata[31:28];
               OFS_BASE_HI: if (!locked) cfg[i].base_hi  <= wdata;
               OFS_SIZE_LO: if (!locked) cfg[i].size_top <= wdata[31:28];
               OFS_SIZE_HI: if (!locked) cfg[i].size_hi  <= wdata;
               OFS_TGT_LO:  if (!locked) cfg[i].tgt_lo   <= wdata;
               OFS_TGT_HI:  if (!locked) cfg[i].tgt_hi   <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == '0)
         rdata = {28'b0, cnt_code};
      for (int i = 0; i < NUM_DEC; i++) begin
         if (blk == BLK_W'(i + 1)) begin
            case (ofs)
               OFS_BASE_LO: rdata = {cfg[i].base_top, 28'b0};
               OFS_BASE_HI: rdata = cfg[i].base_hi;
               OFS_SIZE_LO: rdata = {cfg[i].size_top, 28'b0};
               OFS_SIZE_HI: rdata = cfg[i].size_hi;
               OFS_CTRL:    rdata = {23'b0, cfg[i].commit, 2'b0, cfg[i].ways, cfg[i].gran};
               OFS_TGT_LO:  rdata = cfg[i].tgt_lo;
               OFS_TGT_HI:  rdata = cfg[i].tgt_hi;
               default:     rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/route_dec_match.sv
module route_dec_match
   import addr_route_pkg::*;
(
   input  dec_cfg_t          cfg,
   input  logic              enable,
   input  logic [HPA_W-1:0]  hpa,
   output logic              hit,
   output logic              committed,
   output logic [PORT_W-1:0] port
);

   logic [HPA_W-1:0] base;
   logic [HPA_W-1:0] size;
   logic [HPA_W:0]   limit;
   logic [HPA_W-1:0] shifted;
   logic [3:0]       way_mask;
   logic [2:0]       idx;

   assign base  = {cfg.base_hi, cfg.base_top, 28'b0};
   assign size  = {cfg.size_hi, cfg.size_top, 28'b0};
   assign limit = {1'b0, base} + {1'b0, size};

   assign hit       = enable && (hpa >= base) && ({1'b0, hpa} < limit);
   assign committed = cfg.commit;

   assign shifted  = hpa >> (5'd8 + {1'b0, cfg.gran});
   assign way_mask = (4'd1 << cfg.ways) - 4'd1;
   assign idx      = shifted[2:0] & way_mask[2:0];

   assign port = idx[2] ? cfg.tgt_hi[{idx[1:0], 3'b000} +: PORT_W]
                        : cfg.tgt_lo[{idx[1:0], 3'b000} +: PORT_W];

endmodule

// File: rtl/route_first_pick.sv
module route_first_pick
   import addr_route_pkg::*;
#(
   parameter int NUM_DEC = 4
) (
   input  logic [NUM_DEC-1:0] hit,
   input  logic [NUM_DEC-1:0] committed,
   input  logic [PORT_W-1:0]  port [NUM_DEC],
   output logic               found,
   output logic [PORT_W-1:0]  sel_port
);

   always_comb begin
      found    = 1'b0;
      sel_port = '0;
      // walk downward so the lowest matching index is applied last
      for (int i = NUM_DEC - 1; i >= 0; i--) begin
         if (hit[i]) begin
            found    = committed[i];
            sel_port = committed[i] ? port[i] : '0;
         end
      end
   end

endmodule

// File: rtl/addr_route_lookup.sv
module addr_route_lookup
   import addr_route_pkg::*;
#(
   parameter int NUM_DEC = 4,
   localparam int CFG_AW = $clog2(WORDS_PER * (NUM_DEC + 1))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              lk_valid,
   input  logic [63:0]       lk_addr,
   output logic              rs_valid,
   output logic              rs_found,
   output logic [7:0]        rs_port
);

   if (NUM_DEC < 1 || NUM_DEC > 16) begin : g_bad_count
      $error("NUM_DEC must lie in 1..16");
   end

   dec_cfg_t          cfg [NUM_DEC];
   logic [3:0]        cnt_code;
   logic [5:0]        active;
   logic [5:0]        doubled;

   logic [NUM_DEC-1:0] m_hit, m_commit;
   logic [PORT_W-1:0]  m_port [NUM_DEC];

   logic               s1_valid;
   logic [NUM_DEC-1:0] s1_hit, s1_commit;
   logic [PORT_W-1:0]  s1_port [NUM_DEC];

   logic               pick_found;
   logic [PORT_W-1:0]  pick_port;

   route_cfg_bank #(.NUM_DEC(NUM_DEC), .CFG_AW(CFG_AW)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .rdata    (cfg_rdata),
      .cnt_code (cnt_code),
      .cfg      (cfg)
   );

   assign doubled = {1'b0, cnt_code, 1'b0};
   assign active  = (cnt_code == 4'd0)      ? 6'd1 :
                    (doubled > 6'(NUM_DEC)) ? 6'(NUM_DEC) : doubled;

   for (genvar i = 0; i < NUM_DEC; i++) begin : g_match
      route_dec_match match_i (
         .cfg       (cfg[i]),
         .enable    (6'(i) < active),
         .hpa       (lk_addr),
         .hit       (m_hit[i]),
         .committed (m_commit[i]),
         .port      (m_port[i])
      );
   end

   // stage 1: per-decoder compare results
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_hit    <= '0;
         s1_commit <= '0;
         for (int i = 0; i < NUM_DEC; i++) s1_port[i] <= '0;
      end else begin
         s1_valid  <= lk_valid;
         s1_hit    <= m_hit;
         s1_commit <= m_commit;
         for (int i = 0; i < NUM_DEC; i++) s1_port[i] <= m_port[i];
      end
   end

   route_first_pick #(.NUM_DEC(NUM_DEC)) pick_i (
      .hit       (s1_hit),
      .committed (s1_commit),
      .port      (s1_port),
      .found     (pick_found),
      .sel_port  (pick_port)
   );

   // stage 2: registered result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_found <= 1'b0;
         rs_port  <= '0;
      end else begin
         rs_valid <= s1_valid;
         rs_found <= s1_valid && pick_found;
         rs_port  <= (s1_valid && pick_found) ? pick_port : '0;
      end
   end

endmodule

// File: rtl/addr_route_chk.sv
module addr_route_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       lk_valid,
   input logic       rs_valid,
   input logic       rs_found,
   input logic [7:0] rs_port
);

   // R9
   req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> ##2 rs_valid);

   // R9
   idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> ##2 !rs_valid);

   // R6
   found_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_found |-> rs_valid);

   // R9
   miss_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_found |-> rs_port == 8'h00);

endmodule

bind addr_route_lookup addr_route_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_valid (lk_valid),
   .rs_valid (rs_valid),
   .rs_found (rs_found),
   .rs_port  (rs_port)
);

// File: tb/addr_route_lookup_tb_top.sv
module addr_route_lookup_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        lk_valid = 1'b0;
   logic [63:0] lk_addr = '0;
   logic        rs_valid, rs_found;
   logic [7:0]  rs_port;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   addr_route_lookup #(.NUM_DEC(4)) dut_i (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
      .lk_valid, .lk_addr, .rs_valid, .rs_found, .rs_port
   );

   // {address, found, port}
   localparam logic [72:0] VEC [15] = '{
      {64'h0000_0001_0000_0000, 1'b1, 8'h11},
      {64'h0000_0001_0000_0100, 1'b1, 8'h22},
      {64'h0000_0001_0000_0300, 1'b1, 8'h44},
      {64'h0000_0001_0000_0400, 1'b1, 8'h11},
      {64'h0000_0001_0FFF_FFFF, 1'b1, 8'h44},
      {64'h0000_0001_1000_0000, 1'b1, 8'hA0},
      {64'h0000_0001_1000_0A00, 1'b1, 8'hA5},
      {64'h0000_0001_1000_0E00, 1'b1, 8'hA7},
      {64'h0000_0001_1000_0600, 1'b1, 8'hA3},
      {64'h0000_0001_2FFF_FFFF, 1'b1, 8'hA7},
      {64'h0000_0001_3000_0000, 1'b0, 8'h00},
      {64'h0000_0000_FFFF_FFFF, 1'b0, 8'h00},
      {64'h0000_0002_0000_0100, 1'b0, 8'h00},
      {64'h0000_0002_1000_0000, 1'b1, 8'hC0},
      {64'h0000_0003_0000_0000, 1'b0, 8'h00}
   };

   function automatic logic [5:0] wa(int dec, int ofs);
      return 6'((dec + 1) * 8 + ofs);
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(string tag, logic [5:0] a, logic [31:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(tag, 64'(cfg_rdata), 64'(exp));
   endtask

   task automatic look(string tag, logic [63:0] a, logic f, logic [7:0] p);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_valid = 1'b0;
      check({tag, " R9 gap"}, 64'(rs_valid), 64'd0);
      @(negedge clk);
      check({tag, " R9 valid"}, 64'(rs_valid), 64'd1);
      check({tag, " found"}, 64'(rs_found), 64'(f));
      check({tag, " port"}, 64'(rs_port), 64'(p));
   endtask

   task automatic prog(int d, logic [63:0] base, logic [63:0] size,
                       logic [31:0] ctrl, logic [31:0] tlo, logic [31:0] thi);
      wr(wa(d, 4), 32'h0);
      wr(wa(d, 0), base[31:0]);
      wr(wa(d, 1), base[63:32]);
      wr(wa(d, 2), size[31:0]);
      wr(wa(d, 3), size[63:32]);
      wr(wa(d, 5), tlo);
      wr(wa(d, 6), thi);
      wr(wa(d, 4), ctrl);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 rs_valid", 64'(rs_valid), 64'd0);
      rst_n = 1'b1;
      rd("R11 capability", 6'd0, 32'h0);
      rd("R11 ctrl", wa(0, 4), 32'h0);

      // R2 low-word truncation
      wr(wa(0, 0), 32'h1234_5678);
      rd("R2 base low", wa(0, 0), 32'h1000_0000);
      wr(wa(0, 2), 32'hFFFF_FFFF);
      rd("R2 size low", wa(0, 2), 32'hF000_0000);

      prog(0, 64'h1_0000_0000, 64'h1000_0000, 32'h120, 32'h4433_2211, 32'h8877_6655);
      prog(1, 64'h1_1000_0000, 64'h2000_0000, 32'h131, 32'hA3A2_A1A0, 32'hA7A6_A5A4);
      prog(2, 64'h2_0000_0000, 64'h1000_0000, 32'h000, 32'h0000_0000, 32'h0000_0000);
      prog(3, 64'h2_0000_0000, 64'h2000_0000, 32'h100, 32'h0000_00C0, 32'h0000_0000);
      wr(6'd0, 32'h2);
      rd("R2 base high", wa(1, 1), 32'h1);

      // table: R3 bounds, R5 uncommitted first match, R6 miss, R7 index, R8 byte
      for (int i = 0; i < 15; i++) begin
         look($sformatf("vec%0d R3 R5 R6 R7 R8", i), VEC[i][72:9], VEC[i][8], VEC[i][7:0]);
      end

      // R1 count decode
      wr(6'd0, 32'h0);
      look("R1 code0 dec1 off", 64'h1_1000_0000, 1'b0, 8'h00);
      look("R1 code0 dec0 on", 64'h1_0000_0100, 1'b1, 8'h22);
      wr(6'd0, 32'h1);
      look("R1 code1 dec1 on", 64'h1_1000_0000, 1'b1, 8'hA0);
      look("R1 code1 dec3 off", 64'h2_1000_0000, 1'b0, 8'h00);
      wr(6'd0, 32'h7);
      look("R1 code7 capped", 64'h2_1000_0000, 1'b1, 8'hC0);
      wr(6'd0, 32'h2);

      // R10 commit write lock
      wr(wa(0, 1), 32'h5);
      rd("R10 locked base", wa(0, 1), 32'h1);
      wr(wa(0, 5), 32'h0);
      rd("R10 locked tgt", wa(0, 5), 32'h4433_2211);
      look("R10 still routes", 64'h1_0000_0000, 1'b1, 8'h11);
      wr(wa(0, 4), 32'h020);
      rd("R10 ctrl writable", wa(0, 4), 32'h020);
      wr(wa(0, 5), 32'h55);
      rd("R10 unlocked tgt", wa(0, 5), 32'h55);
      look("R5 uncommitted dec0", 64'h1_0000_0000, 1'b0, 8'h00);

      // R4 lowest index wins among committed overlaps
      wr(wa(2, 5), 32'hB0);
      wr(wa(2, 4), 32'h100);
      look("R4 dec2 over dec3", 64'h2_0000_0100, 1'b1, 8'hB0);

      // R9 back-to-back requests
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = 64'h1_1000_0000;
      @(negedge clk);
      lk_addr = 64'h1_1000_0A00;
      @(negedge clk);
      lk_valid = 1'b0;
      check("R9 b2b first valid", 64'(rs_valid), 64'd1);
      check("R9 b2b first port", 64'(rs_port), 64'hA0);
      @(negedge clk);
      check("R9 b2b second valid", 64'(rs_valid), 64'd1);
      check("R9 b2b second port", 64'(rs_port), 64'hA5);
      @(negedge clk);
      check("R9 strobe drops", 64'(rs_valid), 64'd0);

      // R11 reset mid-run
      rst_n = 1'b0;
      #1;
      check("R11 rerst valid", 64'(rs_valid), 64'd0);
      rd("R11 rerst cap", 6'd0, 32'h0);
      rd("R11 rerst tgt", wa(1, 6), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      finish_run();
   end

endmodule